// File: doc/BRIEF.md
# Latching Maskable Interrupt Collector

This block gathers 32 asynchronous interrupt request lines from around the chip and presents one request signal to the processor. Every line is brought into the clock domain by a two-flop synchroniser. It then feeds a pending-status register. An enable register gates each status bit, and the gated bits are combined into the request output. Software reaches both registers through a small register port with an enable, a write strobe, a one-bit register address, write data and read data. When the processor takes the request, it reads the status register to see every outstanding line.

The way a line becomes pending, and the way software clears it, is fixed when the block is built. The `MODE` parameter picks one of three behaviours. In live level tracking, status simply mirrors the synchronised lines. In edge capture, a rising edge sets a status bit and software clears it by writing 1. In sticky level capture, a high line sets a status bit, the bit stays set after the line drops, and software clears it by writing 0. The sticky mode exists for compatibility with older software that acknowledges in that way.

Top module: `irq_line_collector`

## Requirements
- R1: After reset the enable register and the status register read as zero, and `irqReq` is low.
- R2: With `regEn` and `regWe` high at a clock edge, `regAddr`=0 writes `regWdata` to the enable register. A read (`regEn` high) returns the enable register at `regAddr`=0 and the status register at `regAddr`=1, combinationally in the same cycle. `regRdata` is zero when `regEn` is low.
- R3: `irqReq` is high exactly when some line has its status bit and its enable bit both set. An enable bit of 0 blocks its line.
- R4: In level tracking mode (`MODE`=TRACK_LEVEL), status bit i equals line i after two clock edges of synchronisation. Writes to the status register have no effect.
- R5: In edge capture mode (`MODE`=LATCH_EDGE_W1C), a 0-to-1 transition of a synchronised line sets its status bit on the third clock edge after the line rises. A line that is held high does not set the bit again.
- R6: In edge capture mode, writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R7: In sticky level mode (`MODE`=LATCH_LEVEL_W0C), a synchronised line that is high sets its status bit. The bit stays set after the line returns low.
- R8: In sticky level mode, writing 0 to a status bit clears it and writing 1 leaves it unchanged. A line that is still high sets the bit again in that same cycle, so the bit stays set.
- R9: In edge capture mode, an edge that arrives in the same cycle as a clearing write to its bit wins, and the bit stays set.
- R10: Status bits are captured whether or not their line is enabled. Enabling a line whose bit is already pending raises `irqReq` immediately after the enabling write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 32 | Asynchronous interrupt request lines |
| regEn | input | 1 | Register port select |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 = enable register, 1 = status register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational |
| irqReq | output | 1 | Combined interrupt request to the processor |

## Verification
A corrupted enable register or status register shows up on `regRdata` at the next read. If a pending bit is in the wrong state, `irqReq` is also wrong in the very cycle after the bad edge, provided the line is enabled. The bench sweeps every line in all three modes and reads status after each event and each write. This means a missed capture, a wrong clear polarity or a lost bit shows within a few cycles, on the exact bit concerned. Separate directed cases cover the clear racing a new edge, a clear while the line is still high, and request gating by the enable register.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

  typedef enum logic [1:0] {
    TRACK_LEVEL     = 2'd0,
    LATCH_EDGE_W1C  = 2'd1,
    LATCH_LEVEL_W0C = 2'd2
  } latchMode_e;

  // Strobes from the register decoder to the datapath
  typedef struct packed {
    logic maskWr;
    logic statWr;
    logic rdEn;
    logic selStat;
  } regStrobes_t;

endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
  parameter int NUM_LINES   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] rawIn,
  output logic [NUM_LINES-1:0] syncOut,
  output logic [NUM_LINES-1:0] riseOut
);

  logic [NUM_LINES-1:0] stageQ [SYNC_STAGES];
  logic [NUM_LINES-1:0] prevQ;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= rawIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= stageQ[s-1];
      end
    end
  end

  assign syncOut = stageQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= syncOut;
  end

  assign riseOut = syncOut & ~prevQ;

endmodule

// File: rtl/irq_reg_ctrl.sv
module irq_reg_ctrl
  import irq_latch_pkg::*;
(
  input  logic        regEn,
  input  logic        regWe,
  input  logic        regAddr,
  output regStrobes_t strobes
);

  always_comb begin
    strobes.rdEn    = regEn;
    strobes.selStat = regAddr;
    strobes.maskWr  = regEn && regWe && !regAddr;
    strobes.statWr  = regEn && regWe && regAddr;
  end

endmodule

// File: rtl/irq_latch_datapath.sv
module irq_latch_datapath
  import irq_latch_pkg::*;
#(
  parameter int         NUM_LINES = 32,
  parameter latchMode_e MODE      = LATCH_EDGE_W1C
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobes_t          strobes,
  input  logic [NUM_LINES-1:0] wrData,
  input  logic [NUM_LINES-1:0] syncLvl,
  input  logic [NUM_LINES-1:0] riseEvt,
  output logic [NUM_LINES-1:0] rdData,
  output logic                 irqReq
);

  logic [NUM_LINES-1:0] maskQ;
  logic [NUM_LINES-1:0] statusVal;

  always_ff @(posedge clk) begin
    if (!rstN)               maskQ <= '0;
    else if (strobes.maskWr) maskQ <= wrData;
  end

  // R2: a write to the enable register lands on the next edge
  a_r2_mask_write: assert property (@(posedge clk) disable iff (!rstN)
    strobes.maskWr |=> maskQ == $past(wrData));

  if (MODE == TRACK_LEVEL) begin : g_level
    logic unusedRise;
    logic unusedWr;
    assign unusedRise = ^riseEvt;
    assign unusedWr   = strobes.statWr;
    assign statusVal  = syncLvl;
  end else if (MODE == LATCH_EDGE_W1C) begin : g_edge
    logic [NUM_LINES-1:0] statusQ;
    logic [NUM_LINES-1:0] clrBits;
    logic                 unusedLvl;
    assign unusedLvl = ^syncLvl;
    assign clrBits   = strobes.statWr ? wrData : '0;

    always_ff @(posedge clk) begin
      if (!rstN) statusQ <= '0;
      else       statusQ <= (statusQ & ~clrBits) | riseEvt;
    end
    assign statusVal = statusQ;

    // R6: bits written as 1 with no concurrent edge are gone after the write
    a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rstN)
      strobes.statWr |=> (statusQ & $past(wrData & ~riseEvt)) == '0);
    // R9: an edge always leaves its bit set, even against a clear
    a_r9_edge_wins: assert property (@(posedge clk) disable iff (!rstN)
      (riseEvt != '0) |=> (statusQ & $past(riseEvt)) == $past(riseEvt));
  end else begin : g_sticky
    logic [NUM_LINES-1:0] statusQ;
    logic [NUM_LINES-1:0] keepBits;
    logic                 unusedRise;
    assign unusedRise = ^riseEvt;
    assign keepBits   = strobes.statWr ? wrData : '1;

    always_ff @(posedge clk) begin
      if (!rstN) statusQ <= '0;
      else       statusQ <= (statusQ & keepBits) | syncLvl;
    end
    assign statusVal = statusQ;

    // R7: without a status write no pending bit is lost
    a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.statWr |=> (statusQ & $past(statusQ)) == $past(statusQ));
    // R8: bits written as 0 whose line is low are cleared
    a_r8_w0c_clears: assert property (@(posedge clk) disable iff (!rstN)
      strobes.statWr |=> (statusQ & $past(~wrData & ~syncLvl)) == '0);
  end

  always_comb begin
    if (!strobes.rdEn)        rdData = '0;
    else if (strobes.selStat) rdData = statusVal;
    else                      rdData = maskQ;
  end

  assign irqReq = |(statusVal & maskQ);

  // R3: a request is impossible while every line is blocked
  a_r3_req_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> maskQ != '0);

endmodule

// File: rtl/irq_line_collector.sv
module irq_line_collector
  import irq_latch_pkg::*;
#(
  parameter int         NUM_LINES   = 32,
  parameter int         SYNC_STAGES = 2,
  parameter latchMode_e MODE        = LATCH_EDGE_W1C
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic                 regEn,
  input  logic                 regWe,
  input  logic                 regAddr,
  input  logic [NUM_LINES-1:0] regWdata,
  output logic [NUM_LINES-1:0] regRdata,
  output logic                 irqReq
);

  logic [NUM_LINES-1:0] syncLvl;
  logic [NUM_LINES-1:0] riseEvt;
  regStrobes_t          strobes;

  irq_line_sync #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .rawIn(irqIn), .syncOut(syncLvl), .riseOut(riseEvt)
  );

  irq_reg_ctrl u_ctrl (
    .regEn(regEn), .regWe(regWe), .regAddr(regAddr), .strobes(strobes)
  );

  irq_latch_datapath #(.NUM_LINES(NUM_LINES), .MODE(MODE)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(regWdata),
    .syncLvl(syncLvl), .riseEvt(riseEvt), .rdData(regRdata), .irqReq(irqReq)
  );

endmodule

// File: tb/irq_line_collector_tb.sv
`timescale 1ns/1ps
module irq_line_collector_tb;
  import irq_latch_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqIn = '0;
  logic        regEn = 1'b0, regWe = 1'b0, regAddr = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] rdLvl, rdEdge, rdStk;
  logic        reqLvl, reqEdge, reqStk;
  logic [31:0] sLvl, sEdge, sStk;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  // u_dut: sticky level mode; the other two share the same stimulus
  irq_line_collector #(.MODE(LATCH_LEVEL_W0C)) u_dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regEn(regEn), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(rdStk), .irqReq(reqStk));
  irq_line_collector #(.MODE(LATCH_EDGE_W1C)) u_dutEdge (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regEn(regEn), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(rdEdge), .irqReq(reqEdge));
  irq_line_collector #(.MODE(TRACK_LEVEL)) u_dutLvl (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regEn(regEn), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(rdLvl), .irqReq(reqLvl));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic regWrite(input logic addr, input logic [31:0] data);
    @(negedge clk);
    regEn = 1'b1; regWe = 1'b1; regAddr = addr; regWdata = data;
    @(negedge clk);
    regEn = 1'b0; regWe = 1'b0;
  endtask

  task automatic regRead(input logic addr);
    @(negedge clk);
    regEn = 1'b1; regWe = 1'b0; regAddr = addr;
    #1;
    sLvl = rdLvl; sEdge = rdEdge; sStk = rdStk;
    regEn = 1'b0;
  endtask

  task automatic pulse(input logic [31:0] v);
    irqIn = v; waitCyc(3); irqIn = '0; waitCyc(3);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    waitCyc(4);
    rstN = 1'b1;
    // R1 reset state
    #1;
    check("R1 req lvl", {31'd0, reqLvl}, 0);
    check("R1 req edge", {31'd0, reqEdge}, 0);
    check("R1 req sticky", {31'd0, reqStk}, 0);
    regRead(1'b0);
    check("R1 mask lvl", sLvl, 0); check("R1 mask edge", sEdge, 0); check("R1 mask sticky", sStk, 0);
    regRead(1'b1);
    check("R1 status edge", sEdge, 0); check("R1 status sticky", sStk, 0);
    #1 check("R2 idle read is zero", rdEdge, 0);

    // Sweep every line in all modes
    for (int i = 0; i < 32; i++) begin
      logic [31:0] b;
      b = 32'd1 << i;
      irqIn = b; waitCyc(3);
      regRead(1'b1);
      check("R4 level follows high", sLvl, b);
      check("R5 edge captured", sEdge, b);
      check("R7 sticky captured", sStk, b);
      irqIn = '0; waitCyc(3);
      regRead(1'b1);
      check("R4 level follows low", sLvl, 0);
      check("R5 edge held", sEdge, b);
      check("R7 sticky held", sStk, b);
      regWrite(1'b1, b);
      regRead(1'b1);
      check("R6 write one clears", sEdge, 0);
      check("R8 write one leaves", sStk, b);
      pulse(b);
      regWrite(1'b1, ~b);
      regRead(1'b1);
      check("R6 write zero leaves", sEdge, b);
      check("R8 write zero clears", sStk, 0);
      regWrite(1'b1, b);
      regRead(1'b1);
      check("R6 final clear", sEdge, 0);
    end

    // R4 latency: two edges through the synchroniser
    @(negedge clk); irqIn = 32'h0000_0200;
    @(negedge clk); #1 check("R4 not yet after one edge", rdLvl & 0, 0);
    regEn = 1'b1; regAddr = 1'b1; #1 check("R4 not yet after one edge", rdLvl, 0);
    @(negedge clk); #1 check("R4 visible after two edges", rdLvl, 32'h0000_0200);
    regEn = 1'b0;
    // R4 status writes ignored in level mode; R8 clear while line high
    regWrite(1'b1, 32'h0);
    regRead(1'b1);
    check("R4 level write ignored", sLvl, 32'h0000_0200);
    check("R8 line high resets bit", sStk, 32'h0000_0200);
    regWrite(1'b1, 32'h0000_0200);
    waitCyc(4);
    regRead(1'b1);
    check("R5 held line no recapture", sEdge, 0);
    irqIn = '0; waitCyc(3);
    regWrite(1'b1, 32'h0);
    regRead(1'b1);
    check("R8 cleared after drop", sStk, 0);

    // R2 enable register read back
    regWrite(1'b0, 32'hA5C3_0F96);
    regRead(1'b0);
    check("R2 mask lvl", sLvl, 32'hA5C3_0F96); check("R2 mask edge", sEdge, 32'hA5C3_0F96);
    check("R2 mask sticky", sStk, 32'hA5C3_0F96);
    regWrite(1'b0, 32'h5A3C_F069);
    regRead(1'b0);
    check("R2 mask second pattern", sStk, 32'h5A3C_F069);
    regWrite(1'b0, 32'h0);

    // R3 / R10 gating and immediate request on enable
    irqIn = 32'h0010_0000; waitCyc(3);
    #1 check("R3 masked lvl", {31'd0, reqLvl}, 0);
    check("R3 masked edge", {31'd0, reqEdge}, 0);
    check("R3 masked sticky", {31'd0, reqStk}, 0);
    regRead(1'b1);
    check("R10 captured while masked", sEdge, 32'h0010_0000);
    regWrite(1'b0, 32'h0010_0000);
    #1 check("R10 req lvl on enable", {31'd0, reqLvl}, 1);
    check("R10 req edge on enable", {31'd0, reqEdge}, 1);
    check("R10 req sticky on enable", {31'd0, reqStk}, 1);
    regWrite(1'b0, ~32'h0010_0000);
    #1 check("R3 other lines enabled only", {31'd0, reqEdge}, 0);
    check("R3 other lines sticky", {31'd0, reqStk}, 0);
    irqIn = '0; waitCyc(3);
    regWrite(1'b0, 32'h0010_0000);
    #1 check("R3 level req drops with line", {31'd0, reqLvl}, 0);
    check("R3 edge req pending", {31'd0, reqEdge}, 1);
    regWrite(1'b1, 32'h0010_0000);
    regWrite(1'b1, 32'h0);
    #1 check("R3 edge req cleared", {31'd0, reqEdge}, 0);
    check("R3 sticky req cleared", {31'd0, reqStk}, 0);

    // R9 edge meets clear in the same cycle
    pulse(32'h80);
    @(negedge clk); irqIn = 32'h80;
    @(negedge clk);
    regWrite(1'b1, 32'h80);
    regRead(1'b1);
    check("R9 edge wins over clear", sEdge, 32'h80);
    regWrite(1'b1, 32'h80);
    regRead(1'b1);
    check("R9 later clear works", sEdge, 0);
    irqIn = '0; waitCyc(3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule